// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits behind the write path of a parallel NOR-style flash interface. It watches one-cycle write strobes, each carrying a 20-bit address and a 16-bit data word. It recognises the multi-write unlock sequences that guard every data-altering operation. When a sequence completes, it raises a one-clock start pulse for one of four operations: word program, sector erase, block erase or chip erase. With the pulse it presents the captured target address and data.

The same decoder picks which overlay the read path shows: the normal array, the identification words or the query table. In identification mode it also supplies the identification word for the read address. An array engine outside the block reports when it is busy. While it is busy, every write is dropped. Any write that does not fit the next step of a sequence sends the decoder back to idle and to array reads.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, no start pulse is high, `read_mode` is 0 (array), `id_valid` is 0 and `id_word` is 0.
- R2: Every sequence opens with two writes: low byte AAh at address 5555h, then 55h at 2AAAh. If the third write is A0h at 5555h, the fourth write (any address and data) makes `prog_start` high in the clock after it is sampled. In that same clock `op_addr` and `op_data` hold the fourth write's address and data.
- R3: The erase path is the two-write opening, then 80h at 5555h, AAh at 5555h and 55h at 2AAAh. A sixth write of 30h at any address raises `sect_erase_start`. `op_sector` then equals bits 19..11 of that address.
- R4: The same erase path with a sixth write of 50h raises `blk_erase_start`. `op_block` then equals bits 19..15 of that address.
- R5: The same erase path with a sixth write of 10h at 5555h raises `chip_erase_start`.
- R6: The opening followed by 90h at 5555h sets `read_mode` to 1 (identification). One clock after `rd_addr` is applied, a read address of 0 gives `id_word`=00BFh with `id_valid`=1, and an address of 1 gives 2782h with `id_valid`=1. Any read address with a nonzero bit in 19..1 gives `id_valid`=0 and `id_word`=0.
- R7: The opening followed by 98h at 5555h sets `read_mode` to 2 (query).
- R8: A single write of F0h at any address returns `read_mode` to 0. So does the opening followed by F0h at 5555h.
- R9: Address matching for command writes uses only address bits 14..0. The upper data byte is ignored.
- R10: A write that does not fit the expected next step sends the decoder to idle with `read_mode` 0. A later sequence must then start again from the first unlock write.
- R11: While `busy` is 1, every write is ignored, including exit writes and the write that would complete a sequence. Decoder state and `read_mode` are kept.
- R12: At most one start pulse is high in any clock, and each lasts exactly one clock. The decoder is back in idle and array mode on the clock of the pulse, so one further write starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 20 | Write address |
| wr_data | input | 16 | Write data |
| busy | input | 1 | Array engine busy; writes ignored while high |
| rd_addr | input | 20 | Read address for the identification overlay |
| prog_start | output | 1 | One-clock word-program start |
| sect_erase_start | output | 1 | One-clock sector-erase start |
| blk_erase_start | output | 1 | One-clock block-erase start |
| chip_erase_start | output | 1 | One-clock chip-erase start |
| op_addr | output | 20 | Captured target address |
| op_data | output | 16 | Captured program data |
| op_sector | output | 9 | Sector number from the captured address |
| op_block | output | 5 | Block number from the captured address |
| read_mode | output | 2 | 0 array, 1 identification, 2 query |
| id_valid | output | 1 | Identification word valid for rd_addr |
| id_word | output | 16 | Identification word |

## Verification
The collision of interest is a completing command write that lands in the same cycle as a high `busy` flag. The bench drives a full erase sequence and holds `busy` high only on the sixth write. It then checks that no start pulse appears and that the decoder stays armed. Releasing `busy` and repeating only the sixth write must then raise the sector-erase pulse. A second collision sends the exit write while `busy` is high and expects identification mode to survive.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PARM, S_ERS1, S_ERS2, S_ERS3
  } seq_state_t;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0,
    RM_IDENT = 2'd1,
    RM_QUERY = 2'd2
  } read_mode_t;

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_PROG     = 8'hA0;
  localparam logic [7:0] CODE_ERASE    = 8'h80;
  localparam logic [7:0] CODE_IDENT    = 8'h90;
  localparam logic [7:0] CODE_QUERY    = 8'h98;
  localparam logic [7:0] CODE_EXIT     = 8'hF0;
  localparam logic [7:0] CODE_SECT     = 8'h30;
  localparam logic [7:0] CODE_BLK      = 8'h50;
  localparam logic [7:0] CODE_CHIP     = 8'h10;

  typedef struct packed {
    logic at_first;
    logic at_second;
    logic is_unl_a;
    logic is_unl_b;
    logic is_prog;
    logic is_erase;
    logic is_ident;
    logic is_query;
    logic is_exit;
    logic is_sect;
    logic is_blk;
    logic is_chip;
  } cmd_flags_t;
endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int CMD_ADDR_W = 15,
  parameter logic [CMD_ADDR_W-1:0] FIRST_ADDR  = 15'h5555,
  parameter logic [CMD_ADDR_W-1:0] SECOND_ADDR = 15'h2AAA
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output cmd_flags_t        flags
);
  logic [CMD_ADDR_W-1:0] low_addr;
  logic [7:0]            low_byte;

  assign low_addr = addr[CMD_ADDR_W-1:0];
  assign low_byte = data[7:0];

  always_comb begin
    flags.at_first  = (low_addr == FIRST_ADDR);
    flags.at_second = (low_addr == SECOND_ADDR);
    flags.is_unl_a  = (low_byte == CODE_UNLOCK_A);
    flags.is_unl_b  = (low_byte == CODE_UNLOCK_B);
    flags.is_prog   = (low_byte == CODE_PROG);
    flags.is_erase  = (low_byte == CODE_ERASE);
    flags.is_ident  = (low_byte == CODE_IDENT);
    flags.is_query  = (low_byte == CODE_QUERY);
    flags.is_exit   = (low_byte == CODE_EXIT);
    flags.is_sect   = (low_byte == CODE_SECT);
    flags.is_blk    = (low_byte == CODE_BLK);
    flags.is_chip   = (low_byte == CODE_CHIP);
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  cmd_flags_t        flags,
  output logic              prog_start,
  output logic              sect_start,
  output logic              blk_start,
  output logic              chip_start,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output read_mode_t        mode
);
  seq_state_t state_q;
  logic       take;

  assign take = wr_en && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      mode       <= RM_ARRAY;
      prog_start <= 1'b0;
      sect_start <= 1'b0;
      blk_start  <= 1'b0;
      chip_start <= 1'b0;
      op_addr    <= '0;
      op_data    <= '0;
    end else begin
      prog_start <= 1'b0;
      sect_start <= 1'b0;
      blk_start  <= 1'b0;
      chip_start <= 1'b0;
      if (take) begin
        // default outcome of any non-matching step: abort to idle, array reads
        state_q <= S_IDLE;
        mode    <= RM_ARRAY;
        unique case (state_q)
          S_IDLE: if (flags.is_unl_a && flags.at_first) begin
            state_q <= S_UNL1;
            mode    <= mode;
          end
          S_UNL1: if (flags.is_unl_b && flags.at_second) begin
            state_q <= S_UNL2;
            mode    <= mode;
          end
          S_UNL2: if (flags.at_first) begin
            if (flags.is_prog) begin
              state_q <= S_PARM;
              mode    <= mode;
            end else if (flags.is_erase) begin
              state_q <= S_ERS1;
              mode    <= mode;
            end else if (flags.is_ident) begin
              mode    <= RM_IDENT;
            end else if (flags.is_query) begin
              mode    <= RM_QUERY;
            end
          end
          S_PARM: begin
            prog_start <= 1'b1;
            op_addr    <= wr_addr;
            op_data    <= wr_data;
          end
          S_ERS1: if (flags.is_unl_a && flags.at_first) begin
            state_q <= S_ERS2;
            mode    <= mode;
          end
          S_ERS2: if (flags.is_unl_b && flags.at_second) begin
            state_q <= S_ERS3;
            mode    <= mode;
          end
          S_ERS3: begin
            if (flags.is_sect) begin
              sect_start <= 1'b1;
              op_addr    <= wr_addr;
            end else if (flags.is_blk) begin
              blk_start  <= 1'b1;
              op_addr    <= wr_addr;
            end else if (flags.is_chip && flags.at_first) begin
              chip_start <= 1'b1;
              op_addr    <= wr_addr;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: never two starts at once
  a_r12_one_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_start, sect_start, blk_start, chip_start}));

  // R12: a start never repeats on the following clock
  a_r12_single_clock: assert property (@(posedge clk) disable iff (rst)
    (prog_start || sect_start || blk_start || chip_start) |=>
      !(prog_start || sect_start || blk_start || chip_start));

  // R11: a busy cycle leaves sequence state and mode untouched
  a_r11_busy_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(state_q) && $stable(mode)));

  // R2: program only follows an accepted write in the armed state
  a_r2_prog_from_arm: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> ($past(state_q) == S_PARM && $past(take)));
endmodule

// File: rtl/fcd_idrom.sv
module fcd_idrom
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] MFR_WORD = 16'h00BF,
  parameter logic [DATA_W-1:0] DEV_WORD = 16'h2782
) (
  input  logic              clk,
  input  logic              rst,
  input  read_mode_t        mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              id_valid,
  output logic [DATA_W-1:0] id_word
);
  logic hit;

  assign hit = (mode == RM_IDENT) && (rd_addr[ADDR_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      id_valid <= 1'b0;
      id_word  <= '0;
    end else begin
      id_valid <= hit;
      id_word  <= !hit ? '0 : (rd_addr[0] ? DEV_WORD : MFR_WORD);
    end
  end

  // R6: a valid identification word only follows identification mode
  a_r6_valid_needs_ident: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> ($past(mode) == RM_IDENT));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int CMD_ADDR_W = 15,
  parameter int SECT_LSB   = 11,
  parameter int BLK_LSB    = 15,
  parameter logic [CMD_ADDR_W-1:0] FIRST_ADDR  = 15'h5555,
  parameter logic [CMD_ADDR_W-1:0] SECOND_ADDR = 15'h2AAA,
  parameter logic [DATA_W-1:0]     MFR_WORD    = 16'h00BF,
  parameter logic [DATA_W-1:0]     DEV_WORD    = 16'h2782,
  localparam int SECT_W = ADDR_W - SECT_LSB,
  localparam int BLK_W  = ADDR_W - BLK_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prog_start,
  output logic              sect_erase_start,
  output logic              blk_erase_start,
  output logic              chip_erase_start,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [SECT_W-1:0] op_sector,
  output logic [BLK_W-1:0]  op_block,
  output logic [1:0]        read_mode,
  output logic              id_valid,
  output logic [DATA_W-1:0] id_word
);
  cmd_flags_t flags;
  read_mode_t mode;

  fcd_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR_W(CMD_ADDR_W),
    .FIRST_ADDR(FIRST_ADDR), .SECOND_ADDR(SECOND_ADDR)
  ) u_match (
    .addr(wr_addr), .data(wr_data), .flags(flags)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .flags(flags),
    .prog_start(prog_start), .sect_start(sect_erase_start),
    .blk_start(blk_erase_start), .chip_start(chip_erase_start),
    .op_addr(op_addr), .op_data(op_data), .mode(mode)
  );

  fcd_idrom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_WORD(MFR_WORD), .DEV_WORD(DEV_WORD)
  ) u_idrom (
    .clk(clk), .rst(rst), .mode(mode), .rd_addr(rd_addr),
    .id_valid(id_valid), .id_word(id_word)
  );

  assign op_sector = op_addr[ADDR_W-1:SECT_LSB];
  assign op_block  = op_addr[ADDR_W-1:BLK_LSB];
  assign read_mode = mode;
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [19:0] rd_addr = '0;
  logic        prog_start, sect_erase_start, blk_erase_start, chip_erase_start;
  logic [19:0] op_addr;
  logic [15:0] op_data;
  logic [8:0]  op_sector;
  logic [4:0]  op_block;
  logic [1:0]  read_mode;
  logic        id_valid;
  logic [15:0] id_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .prog_start(prog_start),
    .sect_erase_start(sect_erase_start), .blk_erase_start(blk_erase_start),
    .chip_erase_start(chip_erase_start), .op_addr(op_addr), .op_data(op_data),
    .op_sector(op_sector), .op_block(op_block), .read_mode(read_mode),
    .id_valid(id_valid), .id_word(id_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] starts();
    return {prog_start, sect_erase_start, blk_erase_start, chip_erase_start};
  endfunction

  // one write, sampled on the next posedge; returns at the following negedge
  task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic b = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic opening();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic erase_prefix();
    opening();
    wr(20'h05555, 16'h0080);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic idle_clock();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 starts", {28'd0, starts()}, 32'h0);
    chk("R1 read_mode", {30'd0, read_mode}, 32'd0);
    chk("R1 id_valid", {31'd0, id_valid}, 32'd0);
    chk("R1 id_word", {16'd0, id_word}, 32'd0);
  endtask

  task automatic t_program();
    opening();
    wr(20'h05555, 16'h00A0);
    chk("R2 no early start", {28'd0, starts()}, 32'h0);
    wr(20'hABCDE, 16'h1234);
    chk("R2 prog_start", {28'd0, starts()}, 32'h8);
    chk("R2 op_addr", {12'd0, op_addr}, 32'hABCDE);
    chk("R2 op_data", {16'd0, op_data}, 32'h1234);
    idle_clock();
    chk("R12 pulse one clock", {28'd0, starts()}, 32'h0);
    wr(20'h11111, 16'h2222);
    chk("R12 back to idle", {28'd0, starts()}, 32'h0);
  endtask

  task automatic t_sector();
    erase_prefix();
    wr(20'hFE800, 16'h0030);
    chk("R3 sect start", {28'd0, starts()}, 32'h4);
    chk("R3 op_sector", {23'd0, op_sector}, 32'h1FD);
  endtask

  task automatic t_block();
    erase_prefix();
    wr(20'h9C000, 16'h0050);
    chk("R4 blk start", {28'd0, starts()}, 32'h2);
    chk("R4 op_block", {27'd0, op_block}, 32'h13);
  endtask

  task automatic t_chip();
    erase_prefix();
    wr(20'h05555, 16'h0010);
    chk("R5 chip start", {28'd0, starts()}, 32'h1);
    erase_prefix();
    wr(20'h01234, 16'h0010);
    chk("R5 chip needs 5555h", {28'd0, starts()}, 32'h0);
  endtask

  task automatic t_ident();
    opening();
    wr(20'h05555, 16'h0090);
    chk("R6 mode ident", {30'd0, read_mode}, 32'd1);
    rd_addr = 20'h00000; idle_clock();
    chk("R6 mfr word", {15'd0, id_valid, id_word}, {15'd0, 1'b1, 16'h00BF});
    rd_addr = 20'h00001; idle_clock();
    chk("R6 dev word", {15'd0, id_valid, id_word}, {15'd0, 1'b1, 16'h2782});
    rd_addr = 20'h80001; idle_clock();
    chk("R6 upper bits", {15'd0, id_valid, id_word}, 32'd0);
    wr(20'h3C3C3, 16'h00F0);
    chk("R8 single exit", {30'd0, read_mode}, 32'd0);
    rd_addr = 20'h00000; idle_clock();
    chk("R6 array no id", {31'd0, id_valid}, 32'd0);
  endtask

  task automatic t_query();
    opening();
    wr(20'h05555, 16'h0098);
    chk("R7 mode query", {30'd0, read_mode}, 32'd2);
    opening();
    wr(20'h05555, 16'h00F0);
    chk("R8 three-write exit", {30'd0, read_mode}, 32'd0);
  endtask

  task automatic t_masking();
    wr(20'hFD555, 16'h12AA);
    wr(20'h8AAAA, 16'hFF55);
    wr(20'hF5555, 16'hFF90);
    chk("R9 upper bits ignored", {30'd0, read_mode}, 32'd1);
    wr(20'h00000, 16'h00F0);
    chk("R9 exit", {30'd0, read_mode}, 32'd0);
  endtask

  task automatic t_abort();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAB, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'h01000, 16'h5A5A);
    chk("R10 abort no program", {28'd0, starts()}, 32'h0);
    opening();
    wr(20'h05555, 16'h0090);
    wr(20'h05555, 16'h00AA);
    wr(20'h01234, 16'h0000);
    chk("R10 abort leaves ident", {30'd0, read_mode}, 32'd0);
  endtask

  task automatic t_busy();
    opening();
    wr(20'h05555, 16'h0090);
    wr(20'h00000, 16'h00F0, 1'b1);
    chk("R11 exit ignored when busy", {30'd0, read_mode}, 32'd1);
    erase_prefix();
    wr(20'h00800, 16'h0030, 1'b1);
    chk("R11 no start when busy", {28'd0, starts()}, 32'h0);
    wr(20'h00800, 16'h0030);
    chk("R11 armed after busy", {28'd0, starts()}, 32'h4);
    chk("R11 sector 1", {23'd0, op_sector}, 32'h1);
    chk("R12 mode array after start", {30'd0, read_mode}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_sector();
    t_block();
    t_chip();
    t_ident();
    t_query();
    t_masking();
    t_abort();
    t_busy();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule